// File: doc/BRIEF.md
# Wake-up Request Detector Bank

This block watches a set of asynchronous wake-up request lines (a key press, a real-time-clock tick and similar) on behalf of a standby controller. Each channel resynchronizes its line into the local clock domain. It then checks the line against a trigger condition chosen by software: a low level, a high level, a falling edge, a rising edge, or either edge. When the condition is met on an enabled channel, the channel raises a standby-clear request. The standby state machine that consumes these requests is outside this block.

Edge-triggered requests stay pending until software clears them. Level-triggered requests follow the synchronized line for as long as the channel stays enabled. In the either-edge mode the channel also keeps a two-bit record of which edge directions were seen. A clear write wipes that record together with the pending request.

Software reaches the block through a flat register port. Each mode word carries the settings of two channels, one byte each. A separate clear address takes a channel index as its data. A write that tries to change a channel's condition and its enable at the same time is not allowed. The block applies the condition, keeps the enable as it was and flags an error.

Top module: `wakeup_edge_detect`

## Requirements
- R1: Every request line passes through a two-flop synchronizer. In a level mode, a change driven between clock edges shows on `wake_o` after the second following rising edge, and not after the first.
- R2: Condition code 000 triggers while the synchronized line is low, and code 001 triggers while it is high. In these modes `wake_o` follows the line with no memory.
- R3: Code 010 triggers on a falling edge and code 011 on a rising edge. The request appears after the third rising clock edge following the input change, and it stays set until cleared, even after the line returns.
- R4: Code 100 triggers on either edge. Status bits [3:2] of the channel byte record 01 for a rising edge, 10 for a falling edge and 11 once both have been seen.
- R5: Codes 101, 110 and 111 never raise a request.
- R6: A channel whose enable bit is 0 never drives its `wake_o` high, whatever its line does.
- R7: The status bits of a channel read 00 whenever its condition code is not 100.
- R8: A write to address NUM_CH/2 rounded up (the clear address) with a channel index in data bits [7:0] clears that channel's pending request and its status bits. All other channels are left as they were.
- R9: A mode write that changes both a channel's condition code and its enable bit updates the condition, leaves the enable unchanged, and drives `cfg_err_o` high for exactly the cycle after the write.
- R10: Mode word k holds channel 2k in bits [7:0] and channel 2k+1 in bits [15:8]. Within each byte the condition is at [6:4], the status at [3:2] and the enable at [0]. All other bits read 0. After reset every word reads 0.
- R11: `wake_any_o` is high exactly when at least one channel's `wake_o` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_in | input | NUM_CH | Asynchronous wake-up request lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| wake_o | output | NUM_CH | Per-channel standby-clear request |
| wake_any_o | output | 1 | OR of all channel requests |
| cfg_err_o | output | 1 | One-cycle flag for a forbidden mode write |

## Verification
A vector table drives channel 0 through every condition code. Each vector uses a chosen starting level and ending level on the line, so the table separates level codes (the output tracks the final level) from edge codes (only a transition in the right direction sets the request) and from reserved codes. Directed sequences measure synchronizer and detector latency to the exact edge. They also build up a two-direction status record and show it hidden outside the either-edge mode. Further sequences check that a clear write hits one channel while a neighbour stays pending, and they exercise the forbidden combined write and a disabled channel seeing edges.

// File: rtl/wk_pkg.sv
package wk_pkg;

  typedef enum logic [2:0] {
    CND_LOW  = 3'b000,
    CND_HIGH = 3'b001,
    CND_FALL = 3'b010,
    CND_RISE = 3'b011,
    CND_BOTH = 3'b100
  } cond_t;

  // Edge modes latch their request; level modes follow the line.
  function automatic logic is_edge_mode(input logic [2:0] c);
    return (c == CND_FALL) || (c == CND_RISE) || (c == CND_BOTH);
  endfunction

  // Trigger decision from the current sample s and previous sample p.
  function automatic logic cond_trigger(input logic [2:0] c, input logic s, input logic p);
    logic t;
    case (c)
      CND_LOW:  t = ~s;
      CND_HIGH: t = s;
      CND_FALL: t = p & ~s;
      CND_RISE: t = ~p & s;
      CND_BOTH: t = p ^ s;
      default:  t = 1'b0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] smp_o,
  output logic [W-1:0] prv_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] smp_q;
  logic [W-1:0] prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      smp_q  <= '0;
      prv_q  <= '0;
    end else begin
      meta_q <= async_i;
      smp_q  <= meta_q;
      prv_q  <= smp_q;
    end
  end

  assign smp_o = smp_q;
  assign prv_o = prv_q;
endmodule

// File: rtl/wk_chan_core.sv
module wk_chan_core
  import wk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_i,
  input  logic       prv_i,
  input  logic       byte_we_i,
  input  logic [7:0] byte_wd_i,
  input  logic       clr_i,
  output logic       wake_o,
  output logic [7:0] cfg_o,
  output logic       err_o
);
  logic [2:0] cond_q;
  logic       en_q;
  logic       sticky_q;
  logic [1:0] stat_q;
  logic       err_q;

  // Named internal events for the assertions.
  logic illegal_wr;
  logic trig;
  logic edge_mode;
  logic hit;
  logic rise_ev;
  logic fall_ev;

  assign illegal_wr = byte_we_i && (byte_wd_i[6:4] != cond_q) && (byte_wd_i[0] != en_q);
  assign trig       = cond_trigger(cond_q, smp_i, prv_i);
  assign edge_mode  = is_edge_mode(cond_q);
  assign hit        = en_q && edge_mode && trig;
  assign rise_ev    = en_q && (cond_q == CND_BOTH) && smp_i && !prv_i;
  assign fall_ev    = en_q && (cond_q == CND_BOTH) && !smp_i && prv_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q   <= CND_LOW;
      en_q     <= 1'b0;
      sticky_q <= 1'b0;
      stat_q   <= 2'b00;
      err_q    <= 1'b0;
    end else begin
      if (byte_we_i) begin
        cond_q <= byte_wd_i[6:4];
        if (!illegal_wr) en_q <= byte_wd_i[0];
      end
      err_q    <= illegal_wr;
      sticky_q <= (sticky_q && !clr_i) || hit;
      stat_q   <= (stat_q & {2{!clr_i}}) | {fall_ev, rise_ev};
    end
  end

  assign wake_o = en_q && (edge_mode ? sticky_q : trig);
  assign cfg_o  = {1'b0, cond_q, (cond_q == CND_BOTH) ? stat_q : 2'b00, 1'b0, en_q};
  assign err_o  = err_q;

  // R6
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !wake_o);

  // R9
  illegal_keep_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_wr |=> (en_q == $past(en_q)) && err_o);

  // R8
  clr_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit && !rise_ev && !fall_ev) |=> !sticky_q && (stat_q == 2'b00));

  // R7
  stat_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_q != CND_BOTH) |-> (cfg_o[3:2] == 2'b00));

  // R5
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_q > 3'd4) |-> !wake_o);

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q && !clr_i) |=> sticky_q);
endmodule

// File: rtl/wakeup_edge_detect.sv
module wakeup_edge_detect #(
  parameter int NUM_CH   = 4,
  parameter int NUM_REGS = (NUM_CH + 1) / 2,
  parameter int AW       = $clog2(NUM_REGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_in,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [31:0]       rd_data,
  output logic [NUM_CH-1:0] wake_o,
  output logic              wake_any_o,
  output logic              cfg_err_o
);
  localparam logic [AW-1:0] CLR_ADDR = AW'(NUM_REGS);

  logic [NUM_CH-1:0] smp;
  logic [NUM_CH-1:0] prv;
  logic [NUM_CH-1:0] err;
  logic [7:0]        cfg      [NUM_CH];
  logic [31:0]       reg_word [NUM_REGS];

  wk_sync #(.W(NUM_CH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (req_in),
    .smp_o   (smp),
    .prv_o   (prv)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic byte_we;
    logic clr;
    assign byte_we = wr_en && (wr_addr == AW'(c / 2));
    assign clr     = wr_en && (wr_addr == CLR_ADDR) && (wr_data[7:0] == 8'(c));

    wk_chan_core u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_i     (smp[c]),
      .prv_i     (prv[c]),
      .byte_we_i (byte_we),
      .byte_wd_i (wr_data[8*(c%2) +: 8]),
      .clr_i     (clr),
      .wake_o    (wake_o[c]),
      .cfg_o     (cfg[c]),
      .err_o     (err[c])
    );
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
    if (2 * r + 1 < NUM_CH) begin : g_pair
      assign reg_word[r] = {16'h0000, cfg[2*r+1], cfg[2*r]};
    end else begin : g_single
      assign reg_word[r] = {24'h000000, cfg[2*r]};
    end
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (rd_addr == AW'(r)) rd_data = reg_word[r];
    end
  end

  assign wake_any_o = |wake_o;
  assign cfg_err_o  = |err;
endmodule

// File: tb/wakeup_edge_detect_bench.sv
module wakeup_edge_detect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int AW  = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] req_in = '0;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [31:0]    wr_data = '0;
  logic [AW-1:0]  rd_addr = '0;
  logic [31:0]    rd_data;
  logic [NCH-1:0] wake_o;
  logic           wake_any_o;
  logic           cfg_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wakeup_edge_detect u_wakeup_edge_detect (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .wake_o(wake_o),
    .wake_any_o(wake_any_o), .cfg_err_o(cfg_err_o)
  );

  // Vector: {cond[2:0], start, end, exp_wake, exp_stat[1:0]} for channel 0.
  localparam int NV = 14;
  localparam logic [7:0] VEC [NV] = '{
    {3'b000, 1'b1, 1'b0, 1'b1, 2'b00},
    {3'b000, 1'b0, 1'b1, 1'b0, 2'b00},
    {3'b001, 1'b0, 1'b1, 1'b1, 2'b00},
    {3'b001, 1'b1, 1'b0, 1'b0, 2'b00},
    {3'b010, 1'b1, 1'b0, 1'b1, 2'b00},
    {3'b010, 1'b0, 1'b1, 1'b0, 2'b00},
    {3'b011, 1'b0, 1'b1, 1'b1, 2'b00},
    {3'b011, 1'b1, 1'b0, 1'b0, 2'b00},
    {3'b100, 1'b0, 1'b1, 1'b1, 2'b01},
    {3'b100, 1'b1, 1'b0, 1'b1, 2'b10},
    {3'b100, 1'b1, 1'b1, 1'b0, 2'b00},
    {3'b101, 1'b0, 1'b1, 1'b0, 2'b00},
    {3'b110, 1'b1, 1'b0, 1'b0, 2'b00},
    {3'b111, 1'b0, 1'b1, 1'b0, 2'b00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [AW-1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // Read-modify-write of one channel byte: {0, cond, 00, 0, en}.
  task automatic set_chan(input int ch, input logic [2:0] cond, input logic en);
    logic [31:0] w;
    reg_read(AW'(ch / 2), w);
    w[8*(ch%2) +: 8] = {1'b0, cond, 3'b000, en};
    reg_write(AW'(ch / 2), w);
  endtask

  task automatic clear_chan(input int ch);
    reg_write(AW'(2), 32'(ch));
  endtask

  function automatic logic [1:0] stat_of(input logic [31:0] w, input int ch);
    return w[8*(ch%2) + 2 +: 2];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [2:0]  cur0;
    cur0 = 3'b000;
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R10 reset state and readback layout
    reg_read(2'd0, w); check("R10 reset word0", w, 32'h0);
    reg_read(2'd1, w); check("R10 reset word1", w, 32'h0);
    check("R11 reset wake_any", {31'b0, wake_any_o}, 32'h0);
    check("R9 reset cfg_err", {31'b0, cfg_err_o}, 32'h0);

    // Table walk over all codes on channel 0 (R2 R3 R4 R5)
    for (int i = 0; i < NV; i++) begin
      logic [2:0] vc;
      logic vs, ve, vw;
      logic [1:0] vst;
      {vc, vs, ve, vw, vst} = VEC[i];
      set_chan(0, cur0, 1'b0);
      req_in[0] = vs;
      tick(4);
      set_chan(0, vc, 1'b0);
      cur0 = vc;
      set_chan(0, vc, 1'b1);
      clear_chan(0);
      tick(4);
      req_in[0] = ve;
      tick(4);
      check($sformatf("R2/R3/R4/R5 vec%0d wake", i), {31'b0, wake_o[0]}, {31'b0, vw});
      reg_read(2'd0, w);
      check($sformatf("R4/R7 vec%0d status", i), {30'b0, stat_of(w, 0)}, {30'b0, vst});
    end

    // R4 both directions accumulate to 11
    set_chan(0, cur0, 1'b0);
    req_in[0] = 1'b0; tick(4);
    set_chan(0, 3'b100, 1'b0); cur0 = 3'b100;
    set_chan(0, 3'b100, 1'b1);
    clear_chan(0);
    req_in[0] = 1'b1; tick(4);
    req_in[0] = 1'b0; tick(4);
    reg_read(2'd0, w);
    check("R4 both edges status", {30'b0, stat_of(w, 0)}, 32'd3);
    check("R10 word0 layout", w, 32'h0000_004D);
    // R7 hidden outside both-edge mode
    set_chan(0, 3'b010, 1'b1); cur0 = 3'b010;
    reg_read(2'd0, w);
    check("R7 status hidden", {30'b0, stat_of(w, 0)}, 32'd0);

    // R8 clear one channel only; R11 OR output
    set_chan(0, 3'b100, 1'b1); cur0 = 3'b100;
    set_chan(1, 3'b011, 1'b0);
    set_chan(1, 3'b011, 1'b1);
    clear_chan(0); clear_chan(1);
    req_in[1:0] = 2'b11; tick(4);
    check("R8 pre ch0 wake", {31'b0, wake_o[0]}, 32'd1);
    check("R8 pre ch1 wake", {31'b0, wake_o[1]}, 32'd1);
    clear_chan(0);
    reg_read(2'd0, w);
    check("R8 ch0 cleared", {31'b0, wake_o[0]}, 32'd0);
    check("R8 ch0 status wiped", {30'b0, stat_of(w, 0)}, 32'd0);
    check("R8 ch1 untouched", {31'b0, wake_o[1]}, 32'd1);
    check("R11 any with one", {31'b0, wake_any_o}, 32'd1);
    clear_chan(1);
    check("R11 any none", {31'b0, wake_any_o}, 32'd0);

    // R9 forbidden combined write on channel 2
    reg_write(2'd1, 32'h0000_0031);
    check("R9 err flagged", {31'b0, cfg_err_o}, 32'd1);
    reg_read(2'd1, w);
    check("R9 cond applied en kept", w, 32'h0000_0030);
    tick(1);
    check("R9 err one cycle", {31'b0, cfg_err_o}, 32'd0);

    // R6 disabled channel ignores edges
    req_in[2] = 1'b1; tick(4);
    check("R6 disabled no wake", {31'b0, wake_o[2]}, 32'd0);

    // R3 edge latency and stickiness on channel 2
    set_chan(2, 3'b011, 1'b1);
    req_in[2] = 1'b0; tick(4);
    clear_chan(2);
    tick(1);
    req_in[2] = 1'b1;
    tick(2);
    check("R3 not yet after two edges", {31'b0, wake_o[2]}, 32'd0);
    tick(1);
    check("R3 set after three edges", {31'b0, wake_o[2]}, 32'd1);
    req_in[2] = 1'b0; tick(4);
    check("R3 sticky after return", {31'b0, wake_o[2]}, 32'd1);

    // R1 level latency on channel 3
    set_chan(3, 3'b001, 1'b0);
    set_chan(3, 3'b001, 1'b1);
    tick(3);
    req_in[3] = 1'b1;
    tick(1);
    check("R1 after one edge", {31'b0, wake_o[3]}, 32'd0);
    tick(1);
    check("R1 after two edges", {31'b0, wake_o[3]}, 32'd1);
    req_in[3] = 1'b0; tick(2);
    check("R2 level follows back", {31'b0, wake_o[3]}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule